// File: doc/BRIEF.md
# Partitioned Packed Integer ALU

This block is a single-cycle vector arithmetic unit for a 64-bit datapath. It treats each operand word as a row of independent lanes. A run-time size select divides the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane of the result depends only on the same lane of the two operands, and all lanes are worked on at once.

An opcode picks the operation. The arithmetic operations are add, subtract and low-half multiply. The compare operations are equal and signed greater-than. The bitwise operations are AND, AND-NOT, OR and XOR. The shift operations are left logical and right logical. The carry chain, the compare logic and the shifters are all cut at the lane boundaries chosen by the size select, so no bit passes from one lane into its neighbour.

When the input strobe is high, the block accepts the operands. The result and a valid flag appear in registers on the next clock edge. The block has no state machine. Its only state is the output register, which is loaded when input is accepted and holds its value otherwise.

Top module: `packed_lane_alu`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, out_valid is 0 and result is all zeros until the first accepted input.
- R2: out_valid equals in_valid from the previous clock edge. result is loaded on the edge that follows an accepted input (in_valid high). When in_valid is low, result keeps its previous value.
- R3: op 0 is add and op 1 is subtract (A minus B). Each wraps modulo the lane width, and no carry or borrow crosses into the next lane. lane_sel 0 selects 8-bit lanes, 1 selects 16-bit lanes, and both 2 and 3 select 32-bit lanes.
- R4: op 2 is compare-equal and op 3 is signed compare A greater than B. Each result lane is all ones when the condition holds and all zeros when it does not.
- R5: op 4 is A AND B, op 5 is (NOT A) AND B, op 6 is A OR B and op 7 is A XOR B. Each acts bitwise across the whole word.
- R6: op 8 is shift left logical and op 9 is shift right logical of each lane of A. Every lane uses the same count, opb[7:0]. A count equal to or greater than the lane width gives a zero lane.
- R7: op 10 multiplies 16-bit lanes and keeps the low 16 bits of each product. It always uses 16-bit lanes, whatever the value of lane_sel.
- R8: op values 11 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are accepted this cycle |
| op | input | 4 | Operation code (see R3 to R8) |
| lane_sel | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B; opb[7:0] is the shift count |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 64 | Registered result |

## Verification
The assertions assume that in_valid, op, lane_sel and both operands are stable and known at each rising edge. They also assume that any opcode value may arrive, including the unused codes. The bench changes inputs only on the falling edge and drives every field with a defined value. Random opcodes are drawn over the full 4-bit range. For shift operations, the random shift count is drawn from 0 to 39, so it falls on both sides of each lane width.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CEQ  = 4'd2,
        OP_CGT  = 4'd3,
        OP_AND  = 4'd4,
        OP_ANDN = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_MUL  = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B32X = 2'd3
    } lane_e;

    localparam int NUM_SIZES = 3;
    localparam int CNT_W     = 8;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
    import alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        lane_sel,
    output logic [DATA_W-1:0] sum
);
    localparam int NB = DATA_W / 8;

    logic [NB-1:0] cout;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        localparam bit AT16 = (k % 2) == 0;
        localparam bit AT32 = (k % 4) == 0;
        logic       cut;
        logic       cin;
        logic [7:0] bx;

        assign cut = (lane_sel == LANE_B8) ||
                     (lane_sel == LANE_B16 && AT16) ||
                     (lane_sel[1] && AT32);
        assign bx  = b[k*8 +: 8] ^ {8{sub}};

        if (k == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = cut ? sub : cout[k-1];
        end

        if (k < NB - 1) begin : g_carry
            assign {cout[k], sum[k*8 +: 8]} =
                {1'b0, a[k*8 +: 8]} + {1'b0, bx} + {8'd0, cin};
        end else begin : g_last
            assign cout[k] = 1'b0;
            assign sum[k*8 +: 8] = a[k*8 +: 8] + bx + {7'd0, cin};
        end
    end
endmodule

// File: rtl/lane_compare.sv
module lane_compare
    import alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              gt,
    input  logic [1:0]        lane_sel,
    output logic [DATA_W-1:0] mask
);
    logic [NUM_SIZES-1:0][DATA_W-1:0] per_size;

    for (genvar w = 0; w < NUM_SIZES; w++) begin : g_size
        localparam int LW = 8 << w;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic hit;
            assign hit = gt ? ($signed(a[l*LW +: LW]) > $signed(b[l*LW +: LW]))
                            : (a[l*LW +: LW] == b[l*LW +: LW]);
            assign per_size[w][l*LW +: LW] = {LW{hit}};
        end
    end

    always_comb begin
        unique case (lane_sel)
            LANE_B8:  mask = per_size[0];
            LANE_B16: mask = per_size[1];
            default:  mask = per_size[2];
        endcase
    end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              right,
    input  logic [1:0]        lane_sel,
    output logic [DATA_W-1:0] y
);
    logic [NUM_SIZES-1:0][DATA_W-1:0] per_size;

    for (genvar w = 0; w < NUM_SIZES; w++) begin : g_size
        localparam int LW = 8 << w;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] src;
            assign src = a[l*LW +: LW];
            assign per_size[w][l*LW +: LW] =
                (cnt >= CNT_W'(LW)) ? '0 : (right ? (src >> cnt) : (src << cnt));
        end
    end

    always_comb begin
        unique case (lane_sel)
            LANE_B8:  y = per_size[0];
            LANE_B16: y = per_size[1];
            default:  y = per_size[2];
        endcase
    end
endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NM = DATA_W / 16;

    logic [DATA_W-1:0] as_y, cmp_y, sh_y, mul_y, nxt;

    lane_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(opa), .b(opb), .sub(op == OP_SUB), .lane_sel(lane_sel), .sum(as_y)
    );

    lane_compare #(.DATA_W(DATA_W)) u_cmp (
        .a(opa), .b(opb), .gt(op == OP_CGT), .lane_sel(lane_sel), .mask(cmp_y)
    );

    lane_shifter #(.DATA_W(DATA_W)) u_shift (
        .a(opa), .cnt(opb[CNT_W-1:0]), .right(op == OP_SRL),
        .lane_sel(lane_sel), .y(sh_y)
    );

    for (genvar l = 0; l < NM; l++) begin : g_mul
        assign mul_y[l*16 +: 16] = opa[l*16 +: 16] * opb[l*16 +: 16];
    end

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: nxt = as_y;
            OP_CEQ, OP_CGT: nxt = cmp_y;
            OP_AND:         nxt = opa & opb;
            OP_ANDN:        nxt = ~opa & opb;
            OP_OR:          nxt = opa | opb;
            OP_XOR:         nxt = opa ^ opb;
            OP_SLL, OP_SRL: nxt = sh_y;
            OP_MUL:         nxt = mul_y;
            default:        nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt;
        end
    end

    function automatic bit bytes_are_masks(logic [DATA_W-1:0] v);
        bit ok = 1'b1;
        for (int k = 0; k < DATA_W / 8; k++)
            if (v[k*8 +: 8] != 8'h00 && v[k*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R4
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CEQ || op == OP_CGT)) |=> bytes_are_masks(result));

    // R6
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SLL || op == OP_SRL) && opb[CNT_W-1:0] >= 8'd32)
        |=> (result == '0));

    // R5
    xor_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_XOR && opa == opb) |=> (result == '0));

    // R8
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_MUL) |=> (result == '0));
endmodule

// File: tb/packed_lane_alu_test.sv
module packed_lane_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lane_sel = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    packed_lane_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .lane_sel(lane_sel), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(logic [3:0] o, logic [1:0] ls,
                                          logic [63:0] a, logic [63:0] b);
        int w;
        logic [63:0] res = '0;
        logic [63:0] m, la, lb, r, msb;
        int cnt = int'(b[7:0]);
        if (o == 4'd10) w = 16;
        else if (ls == 2'd0) w = 8;
        else if (ls == 2'd1) w = 16;
        else w = 32;
        m   = (64'd1 << w) - 64'd1;
        msb = 64'd1 << (w - 1);
        for (int l = 0; l < 64 / w; l++) begin
            la = (a >> (l * w)) & m;
            lb = (b >> (l * w)) & m;
            case (o)
                4'd0:  r = (la + lb) & m;
                4'd1:  r = (la - lb) & m;
                4'd2:  r = (la == lb) ? m : 64'd0;
                4'd3:  r = ((la ^ msb) > (lb ^ msb)) ? m : 64'd0;
                4'd4:  r = la & lb;
                4'd5:  r = ~la & lb & m;
                4'd6:  r = la | lb;
                4'd7:  r = la ^ lb;
                4'd8:  r = (cnt >= w) ? 64'd0 : ((la << cnt) & m);
                4'd9:  r = (cnt >= w) ? 64'd0 : (la >> cnt);
                4'd10: r = (la * lb) & m;
                default: r = 64'd0;
            endcase
            res |= r << (l * w);
        end
        return res;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        if (o <= 4'd1) return "R3";
        if (o <= 4'd3) return "R4";
        if (o <= 4'd7) return "R5";
        if (o <= 4'd9) return "R6";
        if (o == 4'd10) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [1:0] ls, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        op = o; lane_sel = ls; opa = a; opb = b; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R2", {63'd0, out_valid}, 64'd1);
        check(tag_of(o), result, model(o, ls, a, b));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        #1;
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", result, 64'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", result, 64'd0);

        // R3 lane wrap with no carry across lanes, each size and reserved size 3
        apply(4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
        apply(4'd0, 2'd1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
        apply(4'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
        apply(4'd1, 2'd0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
        apply(4'd1, 2'd3, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
        // R4 signed compare edges
        apply(4'd3, 2'd0, 64'h80_7F_00_FF_01_80_7F_00, 64'h7F_80_FF_00_00_80_7F_01);
        apply(4'd2, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_0000);
        apply(4'd3, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000);
        // R5
        apply(4'd5, 2'd0, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF);
        apply(4'd7, 2'd1, 64'hDEAD_BEEF_DEAD_BEEF, 64'hDEAD_BEEF_DEAD_BEEF);
        // R6 counts around lane widths
        apply(4'd8, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7);
        apply(4'd8, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8);
        apply(4'd9, 2'd1, 64'h8000_8000_8000_8000, 64'd15);
        apply(4'd9, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32);
        apply(4'd8, 2'd2, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0100);
        // R7 lane_sel ignored for multiply
        apply(4'd10, 2'd0, 64'h00FF_FFFF_1234_0003, 64'h00FF_FFFF_0010_0005);
        apply(4'd10, 2'd2, 64'h8000_0002_0101_FFFF, 64'h0002_8000_0101_0002);
        // R8
        apply(4'd12, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_1111_1111_1111);
        apply(4'd15, 2'd0, 64'h1, 64'h1);

        // R2 result held while in_valid is low and inputs change
        apply(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h1000_0000_0000_0001);
        held = model(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h1000_0000_0000_0001);
        opa = 64'hFFFF_FFFF_FFFF_FFFF; op = 4'd0;
        @(posedge clk); #1;
        check("R2", {63'd0, out_valid}, 64'd0);
        check("R2", result, held);

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  o  = 4'($urandom);
            logic [1:0]  ls = 2'($urandom);
            logic [63:0] a  = {$urandom, $urandom};
            logic [63:0] b  = {$urandom, $urandom};
            if (o == 4'd8 || o == 4'd9) b[7:0] = 8'($urandom % 40);
            if (o == 4'd2 && i % 3 == 0) b[31:0] = a[31:0];
            apply(o, ls, a, b);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule